// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing half of a two-wire serial memory. It runs on a fast system clock and oversamples the already-synchronized clock and data lines of the bus. From these it detects start and stop conditions, shifts bytes in and out most significant bit first, and answers its own device address. It pulls the data line low through an open-drain enable, both to acknowledge and to send read data. It also keeps the word-address counter of the memory.

Write data bytes leave the block as single-cycle strobes, each carrying its target address, and a separate page-write controller takes them. That controller also receives a pulse when a stop ends a transaction that wrote data, and it reports back through a busy input while its internal write cycle runs. Read bytes come from the storage array through a synchronous read port with one cycle of latency. The block supports current-address reads, random reads made of a header that only loads the address followed by a repeated start, and sequential reads. The counter keeps its value from one transaction to the next.

Top module: `twsm_eeprom_slave`

## Requirements
- R1: With SCL high, a falling SDA is a start and a rising SDA is a stop. A start received anywhere, including in the middle of a byte or after a run of idle clocks, drops the byte in progress and begins device-address reception again. The word-address counter is left unchanged.
- R2: The device byte arrives MSB first with the pattern 1010 in bits 7..4, strap_i[2:0] in bits 3..1 and the direction in bit 0 (1 = read). On a match the slave pulls SDA low for the ninth clock. On a mismatch it does not acknowledge and ignores the bus until the next start.
- R3: While busy_i is high no device byte is acknowledged. The first matching device byte after busy_i falls is acknowledged.
- R4: After a write header the next two bytes are the word address, high byte first, and each is acknowledged. The counter loads the low ADDR_W bits of the 16-bit value. The remaining upper bits are ignored.
- R5: Each data byte that follows the address is acknowledged and raises wr_valid_o for one cycle, together with wr_addr_o (the counter) and wr_data_o. The counter then advances in its low PAGE_W bits only, so the address wraps inside the page.
- R6: A stop that ends a transaction in which at least one data byte was written raises wr_stop_o for one cycle. A stop after a transaction with no data byte does not.
- R7: A read header returns the byte at the counter, and the counter then holds that address plus one. The value survives across transactions.
- R8: While the master acknowledges, read bytes continue from consecutive addresses, and the address wraps from 2^ADDR_W-1 to 0. A master no-acknowledge ends the read.
- R9: sda_oe_o changes only while SCL is low, after a falling edge, and it is low after reset.
- R10: Each byte sent to the master comes from exactly one single-cycle rd_en_o request. rd_en_o and wr_valid_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized bus clock level |
| sda_i | input | 1 | Synchronized bus data level |
| strap_i | input | 3 | Device-address strap bits |
| busy_i | input | 1 | Internal write cycle in progress |
| sda_oe_o | output | 1 | Pull the data line low when 1 |
| wr_valid_o | output | 1 | Write byte strobe |
| wr_addr_o | output | ADDR_W | Address of the write byte |
| wr_data_o | output | 8 | Write byte |
| wr_stop_o | output | 1 | Stop ending a transaction that wrote data |
| rd_en_o | output | 1 | Array read request |
| rd_addr_o | output | ADDR_W | Array read address |
| rd_data_i | input | 8 | Array read data, valid the cycle after rd_en_o |

## Verification
The bench builds the engine with ADDR_W=6 and PAGE_W=3, which gives a 64-byte array of 8-byte pages. With these sizes a page wrap takes only a few data bytes and the wrap at the end of the array takes a short sequential read, so random transactions reach both. Random transactions mixed with directed ones start near page ends and near the last address. Other directed cases cover strap mismatch, busy refusal, aborts in the middle of a byte and the nine-clock recovery sequence.

// File: rtl/twsm_pkg.sv
package twsm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } twsm_state_e;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;
  localparam int BYTE_BITS = 8;
endpackage

// File: rtl/twsm_bus_edges.sv
module twsm_bus_edges (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, scl_p, sda_q, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      scl_p <= 1'b1;
      sda_q <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= scl_i;
      scl_p <= scl_q;
      sda_q <= sda_i;
      sda_p <= sda_q;
    end
  end

  assign sda_lvl   = sda_q;
  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign start_det = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_det  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/twsm_addr_ctr.sv
module twsm_addr_ctr #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step_full,
  input  logic              step_page,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] CTR_ONE = 1;

  logic [ADDR_W-1:0] page_next;

  generate
    if (PAGE_W >= ADDR_W) begin : g_flat
      assign page_next = addr + CTR_ONE;
    end else begin : g_paged
      localparam logic [PAGE_W-1:0] PG_ONE = 1;
      assign page_next = {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + PG_ONE};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)            addr <= '0;
    else if (load)      addr <= load_val;
    else if (step_full) addr <= addr + CTR_ONE;
    else if (step_page) addr <= page_next;
  end
endmodule

// File: rtl/twsm_eeprom_slave.sv
module twsm_eeprom_slave
  import twsm_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  output logic              sda_oe_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_stop_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i
);
  localparam logic [3:0] BIT_ACK = 4'(BYTE_BITS);
  localparam logic [3:0] BIT_END = 4'(BYTE_BITS + 1);

  twsm_state_e       state_q;
  logic [3:0]        bitcnt_q;
  logic [7:0]        shreg_q;
  logic [7:0]        ahi_q;
  logic              rnw_q, mack_q, had_wr_q;
  logic [1:0]        rd_pipe_q;

  logic              sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic              byte_fall, ack_fall, addr_match, bus_evt;
  logic              ctr_load, ctr_page, rd_issue;
  logic [ADDR_W-1:0] ctr_addr, load_val;

  twsm_bus_edges u_edges (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  assign bus_evt    = start_det | stop_det;
  assign byte_fall  = scl_fall && (bitcnt_q == BIT_ACK) && !bus_evt;
  assign ack_fall   = scl_fall && (bitcnt_q == BIT_END) && !bus_evt;
  assign addr_match = (shreg_q[7:1] == {DEV_PREFIX, strap_i});
  assign load_val   = ADDR_W'({ahi_q, shreg_q});
  assign ctr_load   = byte_fall && (state_q == ST_ALO);
  assign ctr_page   = byte_fall && (state_q == ST_WDAT);
  assign rd_issue   = ack_fall && (((state_q == ST_DEV) && rnw_q) ||
                                   ((state_q == ST_RDAT) && mack_q));

  twsm_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .load      (ctr_load),
    .load_val  (load_val),
    .step_full (rd_issue),
    .step_page (ctr_page),
    .addr      (ctr_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      bitcnt_q   <= '0;
      shreg_q    <= '0;
      ahi_q      <= '0;
      rnw_q      <= 1'b0;
      mack_q     <= 1'b0;
      had_wr_q   <= 1'b0;
      rd_pipe_q  <= '0;
      sda_oe_o   <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      wr_stop_o  <= 1'b0;
      rd_en_o    <= 1'b0;
      rd_addr_o  <= '0;
    end else begin
      wr_valid_o <= 1'b0;
      wr_stop_o  <= 1'b0;
      rd_en_o    <= 1'b0;
      rd_pipe_q  <= {rd_pipe_q[0], 1'b0};

      if (start_det) begin
        // any start restarts device-address reception
        state_q  <= ST_DEV;
        bitcnt_q <= '0;
        sda_oe_o <= 1'b0;
        had_wr_q <= 1'b0;
      end else if (stop_det) begin
        state_q   <= ST_IDLE;
        sda_oe_o  <= 1'b0;
        wr_stop_o <= had_wr_q;
        had_wr_q  <= 1'b0;
      end else if (state_q != ST_IDLE) begin
        if (scl_rise) begin
          if (bitcnt_q < BIT_ACK) begin
            if (state_q != ST_RDAT) shreg_q <= {shreg_q[6:0], sda_lvl};
            bitcnt_q <= bitcnt_q + 4'd1;
          end else if (bitcnt_q == BIT_ACK) begin
            mack_q   <= ~sda_lvl;
            bitcnt_q <= BIT_END;
          end
        end

        if (byte_fall) begin
          case (state_q)
            ST_DEV: begin
              if (addr_match && !busy_i) begin
                sda_oe_o <= 1'b1;
                rnw_q    <= shreg_q[0];
              end else begin
                state_q <= ST_IDLE;
              end
            end
            ST_AHI: begin
              ahi_q    <= shreg_q;
              sda_oe_o <= 1'b1;
            end
            ST_ALO:  sda_oe_o <= 1'b1;
            ST_WDAT: begin
              sda_oe_o   <= 1'b1;
              wr_valid_o <= 1'b1;
              wr_addr_o  <= ctr_addr;
              wr_data_o  <= shreg_q;
              had_wr_q   <= 1'b1;
            end
            default: sda_oe_o <= 1'b0;
          endcase
        end else if (ack_fall) begin
          sda_oe_o <= 1'b0;
          bitcnt_q <= '0;
          case (state_q)
            ST_DEV:  state_q <= rnw_q ? ST_RDAT : ST_AHI;
            ST_AHI:  state_q <= ST_ALO;
            ST_ALO:  state_q <= ST_WDAT;
            ST_RDAT: if (!mack_q) state_q <= ST_IDLE;
            default: state_q <= state_q;
          endcase
        end else if (scl_fall && (state_q == ST_RDAT) && (bitcnt_q != 4'd0)) begin
          shreg_q  <= {shreg_q[6:0], 1'b0};
          sda_oe_o <= ~shreg_q[6];
        end

        if (rd_issue) begin
          rd_en_o   <= 1'b1;
          rd_addr_o <= ctr_addr;
          rd_pipe_q <= {rd_pipe_q[0], 1'b1};
        end

        if (rd_pipe_q[1] && (state_q == ST_RDAT)) begin
          shreg_q  <= rd_data_i;
          sda_oe_o <= ~rd_data_i[7];
        end
      end
    end
  end
endmodule

// File: rtl/twsm_chk.sv
module twsm_chk (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic sda_oe_o,
  input logic wr_valid_o,
  input logic wr_stop_o,
  input logic rd_en_o
);
  // R9
  sda_oe_rise_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> !scl_i);

  // R10
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en_o && wr_valid_o));

  // R10
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en_o |=> !rd_en_o);

  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o |=> !wr_valid_o);

  // R6
  stop_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stop_o |-> !wr_valid_o);
endmodule

bind twsm_eeprom_slave twsm_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .scl_i      (scl_i),
  .sda_oe_o   (sda_oe_o),
  .wr_valid_o (wr_valid_o),
  .wr_stop_o  (wr_stop_o),
  .rd_en_o    (rd_en_o)
);

// File: tb/twsm_eeprom_slave_tb.sv
`timescale 1ns/1ps
module twsm_eeprom_slave_tb;
  localparam int AW = 6;
  localparam int PW = 3;
  localparam int HALF = 12;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic sda_oe_o, wr_valid_o, wr_stop_o, rd_en_o;
  logic [AW-1:0] wr_addr_o, rd_addr_o;
  logic [7:0] wr_data_o, rd_data = 8'h00;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe_o;

  always #4 clk = ~clk;

  twsm_eeprom_slave #(.ADDR_W(AW), .PAGE_W(PW)) u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .strap_i(STRAP),
    .busy_i(busy), .sda_oe_o(sda_oe_o), .wr_valid_o(wr_valid_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_stop_o(wr_stop_o),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data)
  );

  function automatic logic [7:0] mem_f(input logic [AW-1:0] a);
    return (8'(a) * 8'd29) ^ 8'hA5;
  endfunction
  function automatic logic [AW-1:0] pg_inc(input logic [AW-1:0] a);
    return {a[AW-1:PW], a[PW-1:0] + 3'd1};
  endfunction

  always @(posedge clk) if (rd_en_o) rd_data <= mem_f(rd_addr_o);

  int nchecks = 0, nfail = 0, ncap = 0, nstop = 0, nrd = 0, oe_viol = 0, ovl = 0;
  logic [AW-1:0] cap_a [0:63];
  logic [7:0]    cap_d [0:63];
  logic prev_oe = 1'b0, prev_scl = 1'b1;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_valid_o && ncap < 64) begin
        cap_a[ncap] = wr_addr_o; cap_d[ncap] = wr_data_o; ncap++;
      end
      if (wr_stop_o) nstop++;
      if (rd_en_o) nrd++;
      if (rd_en_o && wr_valid_o) ovl++;
      if (sda_oe_o != prev_oe && scl_m && prev_scl) oe_viol++;
    end
    prev_oe = sda_oe_o;
    prev_scl = scl_m;
  end

  task automatic chk(input string req, input int act, input int exp);
    nchecks++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n); repeat (n) @(negedge clk); endtask

  task automatic m_start();
    sda_m = 1'b1; hold(HALF); scl_m = 1'b1; hold(HALF);
    sda_m = 1'b0; hold(HALF); scl_m = 1'b0; hold(HALF);
  endtask
  task automatic m_stop();
    sda_m = 1'b0; hold(HALF); scl_m = 1'b1; hold(HALF); sda_m = 1'b1; hold(HALF);
  endtask
  task automatic m_clk(input logic b, output logic s);
    sda_m = b; hold(HALF); scl_m = 1'b1; hold(HALF/2);
    s = sda_line; hold(HALF/2); scl_m = 1'b0;
  endtask
  task automatic m_wbyte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) m_clk(v[i], s);
    m_clk(1'b1, s);
    ack = ~s;
  endtask
  task automatic m_rbyte(input logic mack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin m_clk(1'b1, s); v[i] = s; end
    m_clk(~mack, s);
  endtask

  logic [AW-1:0] exp_ctr = '0;
  int bytes_read = 0;

  task automatic do_read(input int n, input string req);
    logic [7:0] v;
    for (int k = 0; k < n; k++) begin
      m_rbyte(k != n - 1, v);
      chk(req, v, mem_f(exp_ctr));
      exp_ctr = exp_ctr + 1'b1;
      bytes_read++;
    end
  endtask

  task automatic hdr(input logic rw, input int exp_ack, input string req);
    logic a;
    m_wbyte({4'b1010, STRAP, rw}, a);
    chk(req, a, exp_ack);
  endtask

  initial begin
    logic a, s;
    logic [7:0] hi, lo, d;
    logic [AW-1:0] ea [0:15];
    logic [7:0] ed [0:15];
    int n, base, st0;
    void'($urandom(32'h5EED1234));
    hold(5);
    chk("R9 reset oe", sda_oe_o, 0);
    chk("R5 reset wr_valid", wr_valid_o, 0);
    chk("R10 reset rd_en", rd_en_o, 0);
    rst = 1'b0; hold(5);

    // R7: current read from reset address 0
    m_start(); hdr(1'b1, 1, "R2 read hdr ack"); do_read(1, "R7 first read"); m_stop();

    // R2: strap mismatch, prefix mismatch, following byte ignored
    st0 = nstop; base = ncap;
    m_start(); m_wbyte({4'b1010, STRAP ^ 3'b001, 1'b0}, a); chk("R2 strap nack", a, 0);
    m_wbyte(8'h12, a); chk("R2 ignored byte nack", a, 0); m_stop();
    m_start(); m_wbyte({4'b1011, STRAP, 1'b1}, a); chk("R2 prefix nack", a, 0); m_stop();
    hold(4);
    chk("R2 no write strobe", ncap - base, 0);
    chk("R6 no stop pulse", nstop - st0, 0);

    // R4 R5 R6: writes, first one crosses the page end
    for (int it = 0; it < 6; it++) begin
      hi = (it == 0) ? 8'hFF : 8'($urandom());
      lo = (it == 0) ? 8'h3D : 8'($urandom());
      n  = (it == 0) ? 10 : 1 + int'($urandom() % 11);
      base = ncap; st0 = nstop;
      m_start(); hdr(1'b0, 1, "R2 write hdr ack");
      m_wbyte(hi, a); chk("R4 hi ack", a, 1);
      m_wbyte(lo, a); chk("R4 lo ack", a, 1);
      exp_ctr = lo[AW-1:0];
      for (int k = 0; k < n; k++) begin
        d = 8'($urandom()); ea[k] = exp_ctr; ed[k] = d;
        m_wbyte(d, a); chk("R5 data ack", a, 1);
        exp_ctr = pg_inc(exp_ctr);
      end
      m_stop(); hold(4);
      chk("R5 strobe count", ncap - base, n);
      for (int k = 0; k < n; k++) begin
        chk("R5 R4 write addr", cap_a[base + k], ea[k]);
        chk("R5 write data", cap_d[base + k], ed[k]);
      end
      chk("R6 stop pulse", nstop - st0, 1);
    end

    // R7 R8: current read continues after page-wrapped write
    m_start(); hdr(1'b1, 1, "R2 read hdr"); do_read(3, "R7 current read"); m_stop();

    // R8: random read wrapping the array end, no stop pulse (R6)
    st0 = nstop;
    m_start(); hdr(1'b0, 1, "R2 dummy hdr");
    m_wbyte(8'hA0, a); m_wbyte(8'h3E, a); exp_ctr = 6'd62;
    m_start(); hdr(1'b1, 1, "R2 random read hdr");
    do_read(4, "R8 wrap read"); m_stop(); hold(4);
    chk("R6 no stop after header only", nstop - st0, 0);

    // R3: busy refusal, then acknowledge
    busy = 1'b1;
    m_start(); hdr(1'b0, 0, "R3 busy nack write"); m_stop();
    m_start(); hdr(1'b1, 0, "R3 busy nack read"); m_stop();
    busy = 1'b0;
    m_start(); hdr(1'b1, 1, "R3 ack after busy"); do_read(1, "R7 persisted"); m_stop();

    // R1: abort mid-byte by repeated start
    m_start(); hdr(1'b0, 1, "R1 hdr");
    m_clk(1'b1, s); m_clk(1'b0, s); m_clk(1'b1, s);
    m_start(); hdr(1'b1, 1, "R1 restart ack"); do_read(1, "R1 counter kept"); m_stop();
    // R1: nine idle clocks then start
    m_start(); hdr(1'b0, 1, "R1 hdr2");
    for (int k = 0; k < 4; k++) m_clk(1'b0, s);
    for (int k = 0; k < 9; k++) m_clk(1'b1, s);
    m_start(); hdr(1'b1, 1, "R1 recovery ack"); do_read(1, "R1 recovery read"); m_stop();

    // R8: random reads
    for (int it = 0; it < 5; it++) begin
      lo = 8'($urandom()); n = 1 + int'($urandom() % 5);
      m_start(); hdr(1'b0, 1, "R4 hdr");
      m_wbyte(8'($urandom()), a); m_wbyte(lo, a); chk("R4 lo ack", a, 1);
      exp_ctr = lo[AW-1:0];
      m_start(); hdr(1'b1, 1, "R2 rd hdr"); do_read(n, "R8 seq read"); m_stop();
    end

    hold(8);
    chk("R9 oe change with SCL high", oe_viol, 0);
    chk("R10 rd/wr overlap", ovl, 0);
    chk("R10 one request per byte", nrd, bytes_read);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchecks++; nfail++;
      $display("FAIL watchdog R1 act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end
endmodule